// File: doc/BRIEF.md
# Configurable Bidirectional GPIO Port

An eight-pin general-purpose port whose pins are each set up through three per-bit control registers: a data latch, a direction register and an option register. Software reaches the registers through a simple request/write-enable bus with one-cycle registered read data. A clear direction bit makes the pin an input, floating or pulled up. A set direction bit makes the pin an output, push-pull or open-drain. On input pins that can raise interrupts, the option bit instead arms the pin as an interrupt source.

Per pin the block drives an output enable, an output value and a pull-up enable toward the pad, and it receives the raw pad level, which it passes through a two-flop synchronizer. An on-chip peripheral can take over any pin listed in a parameter mask by asserting that pin's override enable. The separate interrupt block receives a qualified level per pin. That level idles high whenever the pin is not armed, so an unarmed pin never masks the other pins on a shared interrupt line.

Top module: `gpio_port`

## Requirements
- R1: After reset all three registers are 0. No pin is driven, no pull-up is on, every interrupt level is 1, and reads of the direction and option registers return 0.
- R2: Register addresses are 0 for data, 1 for direction and 2 for option. Address 3 reads 0. Read data appears on the clock edge that samples the read request and holds until the next read. Direction and option read back as written.
- R3: Writing the data register while a pin is an input changes only the latch. The pin stays undriven, and the stored value shows up on the pin once the pin is switched to output.
- R4: Reading the data register returns the pad level of an input pin, taken through two flops. A pad change becomes visible after the second rising edge that follows it.
- R5: An output pin whose option bit is 0 is push-pull: output enable 1, output value equal to the latch. A data read returns the latch.
- R6: An output pin whose option bit is 1 is open-drain. A latch of 0 drives the pin low with output enable 1. A latch of 1 releases the pin with output enable 0.
- R7: An input pin whose option bit is 1 has its pull-up enable set unless the peripheral override is active on it. An output pin never has its pull-up enable set.
- R8: On a pin in the interrupt mask (default 0x0F), direction 0 with option 1 arms the interrupt, and the interrupt level output follows the synchronized pad level. In every other case that output is 1.
- R9: On a pin in the alternate mask (default 0xA5), an asserted override enable forces output enable 1, output value equal to the peripheral value and pull-up off, and a data read returns the synchronized pad level. On pins outside the mask the override has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| pin_i | input | 8 | Raw pad levels |
| pin_oe_o | output | 8 | Per-pin pad output enable |
| pin_out_o | output | 8 | Per-pin pad output value |
| pin_pu_o | output | 8 | Per-pin pull-up enable |
| af_oe_i | input | 8 | Peripheral override enable per pin |
| af_val_i | input | 8 | Peripheral output value per pin |
| int_lvl_o | output | 8 | Qualified level for the interrupt block |

## Verification
A peripheral override can change in the same cycle as a direction or data write that reconfigures the same pin. The bench provokes this by asserting the override while it writes a new direction and latch. It checks that the pad follows the peripheral value during the override, and that the written configuration appears at the pad in the cycle the override drops. The bench also moves pad levels between data reads in random order. Each read is judged against a model of the two-flop latency and the direction-dependent readback source.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    REG_DAT = 2'd0,
    REG_DIR = 2'd1,
    REG_OPT = 2'd2,
    REG_RSV = 2'd3
  } gpio_reg_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         req_i,
  input  logic         we_i,
  input  logic [1:0]   addr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] af_act_i,
  output logic [W-1:0] dat_o,
  output logic [W-1:0] dir_o,
  output logic [W-1:0] opt_o,
  output logic [W-1:0] rdata_o
);
  logic [W-1:0] dat_q, dir_q, opt_q, rd_q, rd_d;
  gpio_reg_e    sel;

  assign sel = gpio_reg_e'(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dat_q <= '0;
      dir_q <= '0;
      opt_q <= '0;
    end else if (req_i && we_i) begin
      case (sel)
        REG_DAT: dat_q <= wdata_i;
        REG_DIR: dir_q <= wdata_i;
        REG_OPT: opt_q <= wdata_i;
        default: ;
      endcase
    end
  end

  // data readback: latch for driven outputs, pad level otherwise
  always_comb begin
    case (sel)
      REG_DAT: rd_d = (dir_q & ~af_act_i & dat_q) | (~(dir_q & ~af_act_i) & lvl_i);
      REG_DIR: rd_d = dir_q;
      REG_OPT: rd_d = opt_q;
      default: rd_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                rd_q <= '0;
    else if (req_i && !we_i)    rd_q <= rd_d;
  end

  assign dat_o   = dat_q;
  assign dir_o   = dir_q;
  assign opt_o   = opt_q;
  assign rdata_o = rd_q;
endmodule

// File: rtl/gpio_pad_ctl.sv
module gpio_pad_ctl #(
  parameter int          W        = 8,
  parameter logic [W-1:0] AF_MASK  = '0,
  parameter logic [W-1:0] IRQ_MASK = '0
) (
  input  logic [W-1:0] dat_i,
  input  logic [W-1:0] dir_i,
  input  logic [W-1:0] opt_i,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] af_oe_i,
  input  logic [W-1:0] af_val_i,
  output logic [W-1:0] af_act_o,
  output logic [W-1:0] oe_o,
  output logic [W-1:0] out_o,
  output logic [W-1:0] pu_o,
  output logic [W-1:0] int_lvl_o
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    logic act;
    if (AF_MASK[i]) begin : g_af
      assign act = af_oe_i[i];
    end else begin : g_noaf
      assign act = 1'b0;
    end

    always_comb begin
      if (act) begin
        oe_o[i]  = 1'b1;
        out_o[i] = af_val_i[i];
      end else if (dir_i[i]) begin
        oe_o[i]  = opt_i[i] ? ~dat_i[i] : 1'b1;  // open-drain releases on 1
        out_o[i] = opt_i[i] ? 1'b0 : dat_i[i];
      end else begin
        oe_o[i]  = 1'b0;
        out_o[i] = 1'b0;
      end
    end

    assign pu_o[i]     = ~act & ~dir_i[i] & opt_i[i];
    assign af_act_o[i] = act;

    if (IRQ_MASK[i]) begin : g_irq
      assign int_lvl_o[i] = (~dir_i[i] & opt_i[i]) ? lvl_i[i] : 1'b1;
    end else begin : g_noirq
      assign int_lvl_o[i] = 1'b1;
    end
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int           NUM_PINS = 8,
  parameter logic [NUM_PINS-1:0] AF_MASK  = NUM_PINS'('hA5),
  parameter logic [NUM_PINS-1:0] IRQ_MASK = NUM_PINS'('h0F)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [1:0]          addr_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  output logic [NUM_PINS-1:0] rdata_o,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] pin_oe_o,
  output logic [NUM_PINS-1:0] pin_out_o,
  output logic [NUM_PINS-1:0] pin_pu_o,
  input  logic [NUM_PINS-1:0] af_oe_i,
  input  logic [NUM_PINS-1:0] af_val_i,
  output logic [NUM_PINS-1:0] int_lvl_o
);
  logic [NUM_PINS-1:0] lvl, dat_q, dir_q, opt_q, af_act;

  gpio_sync #(.W(NUM_PINS)) i_sync (
    .clk_i, .rst_ni, .d_i(pin_i), .q_o(lvl)
  );

  gpio_regs #(.W(NUM_PINS)) i_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
    .lvl_i(lvl), .af_act_i(af_act),
    .dat_o(dat_q), .dir_o(dir_q), .opt_o(opt_q), .rdata_o
  );

  gpio_pad_ctl #(.W(NUM_PINS), .AF_MASK(AF_MASK), .IRQ_MASK(IRQ_MASK)) i_pad (
    .dat_i(dat_q), .dir_i(dir_q), .opt_i(opt_q), .lvl_i(lvl),
    .af_oe_i, .af_val_i, .af_act_o(af_act),
    .oe_o(pin_oe_o), .out_o(pin_out_o), .pu_o(pin_pu_o), .int_lvl_o
  );
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int           W        = 8,
  parameter logic [W-1:0] AF_MASK  = '0,
  parameter logic [W-1:0] IRQ_MASK = '0
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         req_i,
  input logic         we_i,
  input logic [1:0]   addr_i,
  input logic [W-1:0] wdata_i,
  input logic [W-1:0] af_oe_i,
  input logic [W-1:0] af_val_i,
  input logic [W-1:0] pin_oe_o,
  input logic [W-1:0] pin_out_o,
  input logic [W-1:0] pin_pu_o,
  input logic [W-1:0] int_lvl_o,
  input logic [W-1:0] dat_q,
  input logic [W-1:0] dir_q,
  input logic [W-1:0] opt_q
);
  logic [W-1:0] ov;
  assign ov = af_oe_i & AF_MASK;

  a_r1_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> (pin_oe_o == '0 && pin_pu_o == '0 && int_lvl_o == '1));

  a_r2_dir_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == 2'd1) |=> dir_q == $past(wdata_i));

  a_r3_input_undriven: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_oe_o & ~dir_q & ~ov) == '0);

  a_r6_od_never_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_oe_o & pin_out_o & dir_q & opt_q & ~ov) == '0);

  a_r7_pu_not_driven: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_pu_o & pin_oe_o) == '0);

  a_r8_unarmed_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (~int_lvl_o & ~(IRQ_MASK & ~dir_q & opt_q)) == '0);

  a_r9_override: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ov & ~pin_oe_o) == '0) && (((pin_out_o ^ af_val_i) & ov) == '0));

  a_r5_latch_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i && addr_i == 2'd0) |=> $stable(dat_q));
endmodule

bind gpio_port gpio_port_chk #(.W(NUM_PINS), .AF_MASK(AF_MASK), .IRQ_MASK(IRQ_MASK)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .af_oe_i(af_oe_i), .af_val_i(af_val_i),
  .pin_oe_o(pin_oe_o), .pin_out_o(pin_out_o), .pin_pu_o(pin_pu_o),
  .int_lvl_o(int_lvl_o), .dat_q(dat_q), .dir_q(dir_q), .opt_q(opt_q)
);

// File: tb/test_gpio_port.sv
module test_gpio_port;
  localparam int         N   = 8;
  localparam logic [7:0] AFM = 8'hA5;
  localparam logic [7:0] IRM = 8'h0F;

  logic clk = 0, rst_n = 0;
  logic req = 0, we = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, pins = 0, afo = 0, afv = 0;
  logic [7:0] rdata, oe, outv, pu, ilvl;
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] m_dat = 0, m_dir = 0, m_opt = 0;

  always #4 clk = ~clk;

  gpio_port #(.NUM_PINS(N), .AF_MASK(AFM), .IRQ_MASK(IRM)) i_gpio_port (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pin_i(pins), .pin_oe_o(oe),
    .pin_out_o(outv), .pin_pu_o(pu), .af_oe_i(afo), .af_val_i(afv),
    .int_lvl_o(ilvl)
  );

  task automatic check(string r, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
    if (a == 0) m_dat = d; else if (a == 1) m_dir = d; else if (a == 2) m_opt = d;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    @(negedge clk); req = 0; d = rdata;
  endtask

  function automatic logic [7:0] x_act();  return afo & AFM; endfunction
  function automatic logic [7:0] x_oe();
    return x_act() | (~x_act() & m_dir & (m_opt ? 8'h00 : 8'h00)) |
           (~x_act() & m_dir & ~m_opt) | (~x_act() & m_dir & m_opt & ~m_dat);
  endfunction
  function automatic logic [7:0] x_out();
    return (x_act() & afv) | (~x_act() & m_dir & ~m_opt & m_dat);
  endfunction
  function automatic logic [7:0] x_pu();  return ~x_act() & ~m_dir & m_opt; endfunction
  function automatic logic [7:0] x_int(); return ~(IRM & ~m_dir & m_opt) | pins; endfunction
  function automatic logic [7:0] x_rd();
    logic [7:0] l = m_dir & ~x_act();
    return (l & m_dat) | (~l & pins);
  endfunction

  task automatic settle(); repeat (3) @(negedge clk); endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    void'($urandom(32'h5EED_1234));
    repeat (2) @(negedge clk);
    // R1: reset state
    check("R1 oe", oe, 8'h00); check("R1 pu", pu, 8'h00); check("R1 int", ilvl, 8'hFF);
    rst_n = 1;
    rd(1, r); check("R1 dir", r, 8'h00);
    rd(2, r); check("R1 opt", r, 8'h00);
    // R2: map and readback
    wr(1, 8'h3C); rd(1, r); check("R2 dir", r, 8'h3C);
    wr(2, 8'hC3); rd(2, r); check("R2 opt", r, 8'hC3);
    rd(3, r); check("R2 rsv", r, 8'h00);
    wr(1, 8'h00); wr(2, 8'h00);
    // R3: input write touches latch only
    pins = 8'h5A; settle();
    wr(0, 8'hF0);
    check("R3 oe", oe, 8'h00);
    rd(0, r); check("R3 rd", r, 8'h5A);
    wr(1, 8'hFF); check("R3 out", outv, 8'hF0); check("R5 oe", oe, 8'hFF);
    rd(0, r); check("R5 rd", r, 8'hF0);
    // R6: open-drain
    wr(2, 8'hFF); check("R6 oe", oe, 8'h0F); check("R6 out", outv, 8'h00);
    // R4/R8: two-flop latency on armed interrupt pins
    wr(1, 8'h00); wr(2, 8'h0F); pins = 8'h00; settle();
    check("R8 armed", ilvl, 8'hF0);
    pins = 8'h0F;
    @(negedge clk); check("R4 lat1", ilvl, 8'hF0);
    @(negedge clk); check("R4 lat2", ilvl, 8'hFF);
    check("R7 pu", pu, 8'h0F);
    // R9: override outside mask ignored, in mask drives
    afo = 8'hFF; afv = 8'hFF; @(negedge clk);
    check("R9 oe", oe, AFM); check("R9 out", outv, AFM); check("R9 pu", pu, 8'h0A);
    // same-cycle: override while reconfiguring
    wr(0, 8'h00); wr(2, 8'h00); wr(1, 8'hFF);
    check("R9 hold", outv, AFM | 8'h00);
    afo = 8'h00; @(negedge clk);
    check("R9 release oe", oe, 8'hFF); check("R9 release out", outv, 8'h00);
    // random sweep
    for (int k = 0; k < 300; k++) begin
      afo = 8'($urandom); afv = 8'($urandom);
      wr(0, 8'($urandom)); wr(1, 8'($urandom)); wr(2, 8'($urandom));
      pins = 8'($urandom); settle();
      check("R5/R6/R9 oe", oe, x_oe());
      check("R5/R6/R9 out", outv, x_out());
      check("R7 pu", pu, x_pu());
      check("R8 int", ilvl, x_int());
      rd(0, r); check("R4/R5 rd", r, x_rd());
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule